// File: doc/BRIEF.md
# High-Region Memory Window Decoder

This block tells a host-side bridge whether a 32-bit memory address should be claimed for the downstream bus. The top 256 MB of the address space is split into 32 equal slices of 8 MB each, laid end to end from 0xF000_0000 upward. Each slice has its own bit in a 32-bit enable register that software writes over a simple register port. An address is claimed only when it is a memory access, lands in the top region, and the bit for its slice is set. Any set of bits may be enabled at once, and neighbouring set bits behave as one unbroken range.

Two decode results are offered. A combinational result answers in the same cycle for the address on the request pins. A registered result comes from a one-entry valid/ready response stage. That stage accepts a request whenever it is empty or its content is being taken in the same cycle. A response that is not taken stays unchanged and blocks new requests. The enable register clears to zero on reset, so no address is claimed until software opens at least one slice. I/O-port requests are never claimed.

Top module: `hiwin_decode`

## Requirements
- R1: After reset the enable register reads 0 at offset 0x060, and no request is claimed.
- R2: A write with `reg_addr` = 0x060 updates each byte lane `k` of the enable register whose `reg_wstrb[k]` is 1, with `reg_wdata[8k+7:8k]`. `reg_rdata` shows the register while `reg_addr` = 0x060. It reads 0 at any other offset. Writes to any other offset change nothing.
- R3: A valid memory request is claimed exactly when address bits 31:28 equal 0xF and the enable bit indexed by address bits 27:23 is 1. Slice i covers 0xF000_0000 + i·0x80_0000 through that base + 0x7F_FFFF.
- R4: When a request is claimed, the window index equals address bits 27:23. When it is not claimed, the index is 0.
- R5: A request with `req_is_mem` = 0 (I/O-port space) is never claimed, whatever its address and the register contents.
- R6: With the enable register at zero, no address is claimed.
- R7: When enable bits i and i+1 are both set, the last byte of slice i and the first byte of slice i+1 are both claimed. There is no gap at the boundary.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on `rsp_valid`/`rsp_claim`/`rsp_win` right after that edge. It is decoded against the enable value that held before the edge. A register write at the same edge affects only later requests.
- R9: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_claim` and `rsp_win` hold their values.
- R10: `comb_claim` and `comb_win` give the decode of the present `req_addr`/`req_is_mem` in the same cycle. `comb_claim` is 0 whenever `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Decode request valid |
| req_ready | output | 1 | Decode request accepted this cycle |
| req_addr | input | 32 | Host address to decode |
| req_is_mem | input | 1 | 1 = memory access, 0 = I/O-port access |
| comb_claim | output | 1 | Same-cycle claim result |
| comb_win | output | 5 | Same-cycle window index |
| rsp_valid | output | 1 | Registered result valid |
| rsp_ready | input | 1 | Consumer takes the registered result |
| rsp_claim | output | 1 | Registered claim result |
| rsp_win | output | 5 | Registered window index |

## Verification
The combinational results and `reg_rdata` are due in the same cycle as their inputs. The registered result is due one edge after acceptance. A register write becomes visible to reads and to decoding one edge after it is presented. Inputs change just after the falling edge, and all outputs are compared at the next falling edge against a behavioural model. That model keeps the previous enable value for a request accepted at the same edge as a write. It checks the stall hold over several back-pressured cycles, and it places slice boundaries by address range arithmetic rather than by bit slicing.

// File: rtl/hiwin_pkg.sv
package hiwin_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_WIN_BITS  = 5;
  localparam int unsigned DEF_WIN_SHIFT = 23;
  localparam int unsigned DEF_REG_AW    = 12;
  localparam int unsigned DEF_EN_OFS    = 12'h060;

  typedef enum logic [0:0] {
    SEL_NONE   = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/hiwin_enable_reg.sv
module hiwin_enable_reg
  import hiwin_pkg::*;
#(
  parameter int unsigned REG_AW = DEF_REG_AW,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_OFS = DEF_EN_OFS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   enable
);
  localparam int unsigned LANES = DATA_W / 8;

  reg_sel_e sel;
  logic     wr_hit;

  always_comb begin
    sel = (addr == REG_AW'(EN_OFS)) ? SEL_ENABLE : SEL_NONE;
  end

  assign wr_hit = wr_en && (sel == SEL_ENABLE);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (wr_hit && wstrb[b]) begin
        lane_q <= wdata[b*8 +: 8];
      end
    end
    assign enable[b*8 +: 8] = lane_q;
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_ENABLE) begin
      rdata = enable;
    end
  end
endmodule

// File: rtl/hiwin_window_match.sv
module hiwin_window_match
  import hiwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned WIN_BITS  = DEF_WIN_BITS,
  parameter int unsigned WIN_SHIFT = DEF_WIN_SHIFT,
  parameter int unsigned NUM_WIN   = 1 << WIN_BITS,
  parameter int unsigned TAG_W     = ADDR_W - WIN_SHIFT - WIN_BITS
) (
  input  logic                valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                is_mem,
  input  logic [NUM_WIN-1:0]  enable,
  output logic                hit,
  output logic [WIN_BITS-1:0] win
);
  localparam logic [TAG_W-1:0] TOP_TAG = '1;

  logic [TAG_W-1:0]    tag;
  logic [WIN_BITS-1:0] idx;
  logic                in_region;
  logic                unused_low;

  assign tag        = addr[ADDR_W-1 -: TAG_W];
  assign idx        = addr[WIN_SHIFT +: WIN_BITS];
  assign unused_low = ^addr[WIN_SHIFT-1:0];
  assign in_region  = (tag == TOP_TAG);

  always_comb begin
    hit = valid && is_mem && in_region && enable[idx];
    win = hit ? idx : '0;
  end
endmodule

// File: rtl/hiwin_rsp_stage.sv
module hiwin_rsp_stage #(
  parameter int unsigned WIN_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_claim,
  input  logic [WIN_BITS-1:0] in_win,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_claim,
  output logic [WIN_BITS-1:0] out_win
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_claim <= 1'b0;
      out_win   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_claim <= in_claim;
        out_win   <= in_win;
      end
    end
  end
endmodule

// File: rtl/hiwin_decode.sv
module hiwin_decode
  import hiwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned WIN_BITS  = DEF_WIN_BITS,
  parameter int unsigned WIN_SHIFT = DEF_WIN_SHIFT,
  parameter int unsigned REG_AW    = DEF_REG_AW,
  parameter int unsigned EN_OFS    = DEF_EN_OFS,
  parameter int unsigned NUM_WIN   = 1 << WIN_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [NUM_WIN-1:0]   reg_wdata,
  input  logic [NUM_WIN/8-1:0] reg_wstrb,
  output logic [NUM_WIN-1:0]   reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_is_mem,
  output logic                 comb_claim,
  output logic [WIN_BITS-1:0]  comb_win,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_claim,
  output logic [WIN_BITS-1:0]  rsp_win
);
  logic [NUM_WIN-1:0] enable;

  hiwin_enable_reg #(
    .REG_AW(REG_AW),
    .DATA_W(NUM_WIN),
    .EN_OFS(EN_OFS)
  ) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .wstrb (reg_wstrb),
    .rdata (reg_rdata),
    .enable(enable)
  );

  hiwin_window_match #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .WIN_SHIFT(WIN_SHIFT)
  ) u_match (
    .valid (req_valid),
    .addr  (req_addr),
    .is_mem(req_is_mem),
    .enable(enable),
    .hit   (comb_claim),
    .win   (comb_win)
  );

  hiwin_rsp_stage #(
    .WIN_BITS(WIN_BITS)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_claim (comb_claim),
    .in_win   (comb_win),
    .in_ready (req_ready),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_claim(rsp_claim),
    .out_win  (rsp_win)
  );
endmodule

// File: rtl/hiwin_decode_chk.sv
module hiwin_decode_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BITS  = 5,
  parameter int unsigned WIN_SHIFT = 23
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_is_mem,
  input logic                comb_claim,
  input logic [WIN_BITS-1:0] comb_win,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_claim,
  input logic [WIN_BITS-1:0] rsp_win
);
  // R5
  io_never_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_claim |-> (req_is_mem && req_valid));

  // R4
  win_matches_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_claim |-> (comb_win == req_addr[WIN_SHIFT +: WIN_BITS]));

  // R4
  idle_win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_claim |-> (comb_win == '0));

  // R8
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && rsp_claim == $past(comb_claim)
                                  && rsp_win == $past(comb_win)));

  // R9
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_claim) && $stable(rsp_win)));
endmodule

bind hiwin_decode hiwin_decode_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS),
  .WIN_SHIFT(WIN_SHIFT)
) chk_i (.*);

// File: tb/hiwin_decode_tb_top.sv
module hiwin_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_wstrb;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        req_is_mem;
  logic        comb_claim;
  logic [4:0]  comb_win;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_claim;
  logic [4:0]  rsp_win;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  hiwin_decode dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference: range arithmetic over slices, returns slice number or -1
  function automatic int ref_slice(input logic v, input logic [31:0] a,
                                   input logic mem, input logic [31:0] en);
    logic [63:0] lo, hi;
    if (!v || !mem) return -1;
    for (int i = 0; i < 32; i++) begin
      lo = 64'hF000_0000 + 64'(i) * 64'h80_0000;
      hi = lo + 64'h7F_FFFF;
      if (en[i] && {32'd0, a} >= lo && {32'd0, a} <= hi) return i;
    end
    return -1;
  endfunction

  logic [31:0] m_en;
  logic        m_rv, m_rc;
  logic [4:0]  m_rw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rv = 0; m_rc = 0; m_rw = 0;
    end else begin
      int s;
      s = ref_slice(req_valid, req_addr, req_is_mem, m_en);
      if (!m_rv || rsp_ready) begin
        m_rv = req_valid;
        if (req_valid) begin
          m_rc = (s >= 0);
          m_rw = (s >= 0) ? 5'(s) : 5'd0;
        end
      end
      if (reg_wr_en && reg_addr == 12'h060) begin
        for (int k = 0; k < 4; k++)
          if (reg_wstrb[k]) m_en[k*8 +: 8] = reg_wdata[k*8 +: 8];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int s;
      s = ref_slice(req_valid, req_addr, req_is_mem, m_en);
      chk("R8 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) begin
        chk("R8 rsp_claim", 32'(rsp_claim), 32'(m_rc));
        chk("R8 rsp_win", 32'(rsp_win), 32'(m_rw));
      end
      chk("R9 req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      chk("R2 reg_rdata", reg_rdata, (reg_addr == 12'h060) ? m_en : 32'd0);
      chk("R10 comb_claim", 32'(comb_claim), 32'(s >= 0));
      chk("R10 comb_win", 32'(comb_win), (s >= 0) ? 32'(s) : 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic req(input logic [31:0] a, input logic mem);
    req_valid = 1'b1; req_addr = a; req_is_mem = mem;
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d, input logic [3:0] s);
    reg_wr_en = 1'b1; reg_addr = ofs; reg_wdata = d; reg_wstrb = s;
  endtask

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_addr = 12'h060; reg_wdata = 0; reg_wstrb = 0;
    req_valid = 0; req_addr = 0; req_is_mem = 1; rsp_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset rdata", reg_rdata, 32'd0);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    step(); rst_n = 1;

    step(); req(32'hF000_0000, 1); #1;
    chk("R6 zero enable no claim", 32'(comb_claim), 32'd0);
    chk("R1 no claim after reset", 32'(comb_claim), 32'd0);

    step(); req_valid = 0; wr(12'h060, 32'h1, 4'hF);
    step(); reg_wr_en = 0; req(32'hF000_0000, 1); #1;
    chk("R2 rdata after write", reg_rdata, 32'h1);
    chk("R3 slice0 first byte", 32'(comb_claim), 32'd1);
    chk("R4 slice0 index", 32'(comb_win), 32'd0);
    step(); req(32'hF07F_FFFF, 1); #1;
    chk("R3 slice0 last byte", 32'(comb_claim), 32'd1);
    step(); req(32'hF080_0000, 1); #1;
    chk("R3 slice1 disabled", 32'(comb_claim), 32'd0);
    chk("R4 unclaimed index zero", 32'(comb_win), 32'd0);
    step(); req(32'hF000_0000, 0); #1;
    chk("R5 io port not claimed", 32'(comb_claim), 32'd0);
    step(); req(32'h7000_0000, 1); #1;
    chk("R3 below region", 32'(comb_claim), 32'd0);

    step(); req_valid = 0; wr(12'h060, 32'h18, 4'hF);
    step(); wr(12'h060, 32'hAAAA_AAAA, 4'b1000);
    step(); reg_wr_en = 0; #1;
    chk("R2 byte strobe merge", reg_rdata, 32'hAA00_0018);
    step(); wr(12'h064, 32'hFFFF_FFFF, 4'hF);
    step(); reg_wr_en = 0; reg_addr = 12'h064; #1;
    chk("R2 other offset reads zero", reg_rdata, 32'd0);
    reg_addr = 12'h060; #1;
    chk("R2 other offset write ignored", reg_rdata, 32'hAA00_0018);

    step(); req(32'hF1FF_FFFF, 1); #1;
    chk("R7 end of slice3", 32'(comb_claim), 32'd1);
    chk("R7 slice3 index", 32'(comb_win), 32'd3);
    step(); req(32'hF200_0000, 1); #1;
    chk("R7 start of slice4", 32'(comb_claim), 32'd1);
    chk("R7 slice4 index", 32'(comb_win), 32'd4);

    step(); req(32'hF280_0000, 1); wr(12'h060, 32'h20, 4'b0001); #1;
    chk("R8 pre-write comb", 32'(comb_claim), 32'd0);
    step(); reg_wr_en = 0; #1;
    chk("R8 rsp uses old enable", 32'(rsp_claim), 32'd0);
    chk("R10 new enable comb", 32'(comb_claim), 32'd1);
    step(); #1;
    chk("R8 rsp uses new enable", 32'(rsp_claim), 32'd1);
    chk("R8 rsp index", 32'(rsp_win), 32'd5);

    step(); rsp_ready = 0; req(32'h0000_0000, 1); #1;
    chk("R9 ready low under stall", 32'(req_ready), 32'd0);
    for (int i = 0; i < 4; i++) begin
      step(); #1;
      chk("R9 held claim", 32'(rsp_claim), 32'd1);
      chk("R9 held index", 32'(rsp_win), 32'd5);
      chk("R9 held valid", 32'(rsp_valid), 32'd1);
    end
    rsp_ready = 1; #1;
    chk("R9 ready returns", 32'(req_ready), 32'd1);
    step(); req_valid = 0; #1;
    chk("R9 queued request lands", 32'(rsp_claim), 32'd0);

    for (int n = 0; n < 400; n++) begin
      step();
      req_valid  = ($urandom % 4) != 0;
      req_is_mem = ($urandom % 6) != 0;
      req_addr   = ($urandom % 5 == 0) ? $urandom : {4'hF, 28'($urandom)};
      rsp_ready  = ($urandom % 3) != 0;
      if ($urandom % 8 == 0)
        wr(($urandom % 4 == 0) ? 12'h064 : 12'h060, $urandom, 4'($urandom));
      else begin
        reg_wr_en = 0;
        reg_addr  = ($urandom % 5 == 0) ? 12'h064 : 12'h060;
      end
    end
    step(); req_valid = 0; reg_wr_en = 0;
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule